// File: doc/BRIEF.md
# Bus Cycle Termination Classifier

This block sits on the master side of an asynchronous-style bus. It watches the active-low termination inputs: a two-bit data acknowledge, a bus error line and a halt line. It decides how the current bus cycle ends. The sequencer gives it two strobes: a cycle-active strobe, and a sample enable that marks each even bus state. The block takes a first sample at the even state where termination first appears (state N). It takes a second sample two states later (N+2), so that a late error can still override an acknowledge that came early.

The result is a one-hot outcome vector that is valid for one clock, marked by a done strobe. The four outcomes are normal-continue, normal-then-halt, bus-error and retry. For the halt and retry outcomes, a stall output stays high until halt is sampled negated. Only then does the outcome strobe fire. While nothing terminates the cycle, the block keeps sampling on every following even state, which models wait states.

Top module: `bus_term_classifier`

## Requirements
- R1: After reset, `done_o` is 0, `res_o` is 0 and `stall_o` is 0.
- R2: A sample is taken only on a clock edge where `samp_i` is 1. A new cycle starts only if `cyc_i` is also 1. A sample at which neither the acknowledge nor the bus error is asserted changes nothing, and sampling continues at the next even state.
- R3: Acknowledge is asserted when either bit of `ack_n_i` is 0. If acknowledge is asserted at N, and bus error and halt are negated at both N and N+2, the outcome is normal (`res_o` = 4'b0001). It is presented for one clock, starting the clock after the N+2 sample edge.
- R4: If acknowledge is asserted at N, bus error is negated at N and N+2, and halt is asserted at N or at N+2, the outcome is halt-then-continue (`res_o` = 4'b0010). `stall_o` rises the clock after the N+2 sample edge. The outcome appears the clock after the first later sample edge at which halt is negated.
- R5: Bus error asserted at N with halt negated at N gives a bus-error outcome (`res_o` = 4'b0100) after the N+2 sample. This holds whether or not acknowledge is asserted, and halt at N+2 does not change it.
- R6: Acknowledge at N with bus error negated, then bus error asserted at N+2 with halt negated, gives the bus-error outcome.
- R7: Bus error and halt both asserted at N give a retry (`res_o` = 4'b1000). Acknowledge is ignored. Stall is held until halt is sampled negated, as in R4.
- R8: Acknowledge at N, then bus error and halt both asserted at N+2, gives a retry, with the same stall behaviour.
- R9: `res_o` is zero whenever `done_o` is 0, and it has at most one bit set. `done_o` never stays high for two clocks in a row.
- R10: `stall_o` falls in exactly the clock in which `done_o` presents a halt or retry outcome. Normal and bus-error outcomes never raise `stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_i | input | 1 | Bus cycle active |
| samp_i | input | 1 | Even-state sample enable |
| ack_n_i | input | ACK_W | Data acknowledge, active low |
| berr_n_i | input | 1 | Bus error, active low |
| halt_n_i | input | 1 | Halt, active low |
| done_o | output | 1 | Outcome valid strobe |
| res_o | output | 4 | One-hot outcome: bit0 normal, bit1 halt, bit2 bus error, bit3 retry |
| stall_o | output | 1 | Held while halt keeps the bus halted |

## Verification
The bench goes after the cases where the second sample must override the first. The first is a late bus error after an early acknowledge. A design that decides at N would report normal instead of bus-error or retry. Another targeted case is a halt that appears only at N+2, which a one-sample design would miss and report as normal. The bench also drives bus error together with acknowledge to catch a priority inversion. It applies terminations with the sample enable low, or with no cycle active, to catch sampling on the wrong edges. Finally, it holds halt over several even states, so that a stall that releases early or never releases shows up as a mismatch on the very clock it happens.

// File: rtl/bus_term_classifier.sv
module bus_term_classifier #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_i,
  input  logic             samp_i,
  input  logic [ACK_W-1:0] ack_n_i,
  input  logic             berr_n_i,
  input  logic             halt_n_i,
  output logic             done_o,
  output logic [3:0]       res_o,
  output logic             stall_o
);
  localparam logic [3:0] O_NORM  = 4'b0001;
  localparam logic [3:0] O_HALT  = 4'b0010;
  localparam logic [3:0] O_ERR   = 4'b0100;
  localparam logic [3:0] O_RETRY = 4'b1000;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_STALL} st_t;

  st_t        st;
  logic       berr_n_q, halt_n_q;
  logic [3:0] pend, cls;

  wire ack  = ~&ack_n_i;
  wire berr = ~berr_n_i;
  wire halt = ~halt_n_i;

  always_comb begin
    if (berr_n_q)      cls = halt_n_q ? O_RETRY : O_ERR;
    else if (berr)     cls = halt ? O_RETRY : O_ERR;
    else if (halt_n_q || halt) cls = O_HALT;
    else               cls = O_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      berr_n_q <= 1'b0;
      halt_n_q <= 1'b0;
      pend     <= '0;
      done_o   <= 1'b0;
      res_o    <= '0;
    end else begin
      done_o <= 1'b0;
      res_o  <= '0;
      case (st)
        S_IDLE:
          if (cyc_i && samp_i && (ack || berr)) begin
            st       <= S_CHK;
            berr_n_q <= berr;
            halt_n_q <= halt;
          end
        S_CHK:
          if (samp_i) begin
            if (cls[1] || cls[3]) begin
              st   <= S_STALL;
              pend <= cls;
            end else begin
              st     <= S_IDLE;
              done_o <= 1'b1;
              res_o  <= cls;
            end
          end
        S_STALL:
          if (samp_i && !halt) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            res_o  <= pend;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign stall_o = (st == S_STALL);
endmodule

// File: rtl/bus_term_classifier_chk.sv
module bus_term_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done_o,
  input logic [3:0] res_o,
  input logic       stall_o
);
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(res_o));
  p_res_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> res_o == 4'b0);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  p_stall_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> done_o && (res_o[1] || res_o[3]));
  p_stalled_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (res_o[1] || res_o[3])) |-> $past(stall_o));
  p_err_nostall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (res_o[0] || res_o[2])) |-> !stall_o && !$past(stall_o));
endmodule

bind bus_term_classifier bus_term_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .res_o(res_o), .stall_o(stall_o)
);

// File: tb/tb_bus_term_classifier.sv
module tb_bus_term_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_i = 1'b0, samp_i = 1'b0;
  logic [1:0] ack_n_i = 2'b11;
  logic       berr_n_i = 1'b1, halt_n_i = 1'b1;
  logic       done_o, stall_o;
  logic [3:0] res_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  bus_term_classifier #(.ACK_W(2)) dut (.*);

  // behavioural reference: phase 0 waiting, 1 first sample seen, 2 stalled
  int  phase = 0;
  bit  e_n, h_n;
  int  held;
  bit  x_done, x_stall;
  int  x_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; x_done = 0; x_res = 0; x_stall = 0;
    end else begin
      bit a, e, h;
      int verdict;
      a = (ack_n_i != 2'b11); e = !berr_n_i; h = !halt_n_i;
      x_done = 0; x_res = 0;
      if (phase == 0) begin
        if (cyc_i && samp_i && (a || e)) begin phase = 1; e_n = e; h_n = h; end
      end else if (phase == 1) begin
        if (samp_i) begin
          if (e_n && h_n) verdict = 8;
          else if (e_n) verdict = 4;
          else if (e && h) verdict = 8;
          else if (e) verdict = 4;
          else if (h_n || h) verdict = 2;
          else verdict = 1;
          if (verdict == 2 || verdict == 8) begin phase = 2; held = verdict; end
          else begin phase = 0; x_done = 1; x_res = verdict; end
        end
      end else begin
        if (samp_i && !h) begin phase = 0; x_done = 1; x_res = held; end
      end
      x_stall = (phase == 2);
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    cmp("done", done_o, x_done);
    cmp("res", res_o, x_res);
    cmp("stall", stall_o, x_stall);
  end

  // one even state (samp high) followed by one odd state (samp low)
  task automatic evs(bit cyc, bit a, bit e, bit h);
    @(negedge clk);
    cyc_i = cyc; samp_i = 1; ack_n_i = a ? 2'b10 : 2'b11;
    berr_n_i = !e; halt_n_i = !h;
    @(negedge clk);
    samp_i = 0; ack_n_i = 2'b11; berr_n_i = 1; halt_n_i = !h;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      cyc_i = 0; samp_i = 0; ack_n_i = 2'b11; berr_n_i = 1; halt_n_i = 1;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("reset done", done_o, 0);
    cmp("reset res", res_o, 0);
    cmp("reset stall", stall_o, 0);
    rst_n = 1;
    idle(2);

    tag = "R2"; // terminations without samp or cyc, then wait states
    @(negedge clk); cyc_i = 1; samp_i = 0; ack_n_i = 2'b00; berr_n_i = 0;
    @(negedge clk); cyc_i = 0; samp_i = 1; ack_n_i = 2'b01; berr_n_i = 0;
    idle(3);
    evs(1, 0, 0, 0); evs(1, 0, 0, 1); evs(1, 0, 0, 0);
    evs(1, 1, 0, 0); evs(1, 0, 0, 0); idle(3);

    tag = "R3";
    evs(1, 1, 0, 0); evs(1, 0, 0, 0); idle(3);

    tag = "R4"; // halt at N
    evs(1, 1, 0, 1); evs(1, 0, 0, 1); evs(1, 0, 0, 1); evs(1, 0, 0, 0); idle(3);
    tag = "R4"; // halt only at N+2
    evs(1, 1, 0, 0); evs(1, 0, 0, 1); evs(1, 0, 0, 0); idle(3);

    tag = "R5";
    evs(1, 0, 1, 0); evs(1, 0, 0, 0); idle(3);
    evs(1, 1, 1, 0); evs(1, 0, 0, 1); idle(3);

    tag = "R6";
    evs(1, 1, 0, 0); evs(1, 0, 1, 0); idle(3);

    tag = "R7";
    evs(1, 1, 1, 1); evs(1, 0, 0, 1); evs(1, 0, 0, 1); evs(1, 0, 0, 0); idle(3);
    evs(1, 0, 1, 1); evs(1, 0, 0, 0); evs(1, 0, 0, 0); idle(3);

    tag = "R8";
    evs(1, 1, 0, 0); evs(1, 0, 1, 1); evs(1, 0, 0, 1); evs(1, 0, 0, 0); idle(3);

    tag = "R9"; // back-to-back cycles
    evs(1, 1, 0, 0); evs(1, 1, 0, 0); evs(1, 0, 0, 0); evs(1, 0, 1, 0); idle(3);

    tag = "R10";
    evs(1, 1, 0, 1); evs(1, 0, 1, 1); evs(1, 0, 0, 1); evs(1, 0, 0, 0); idle(4);

    summary();
  end
endmodule